// File: doc/BRIEF.md
# Four-Channel Prescaled PWM Timer

The block generates four pulse-width modulated outputs from one system clock and is set up through a 32-bit register port with word addresses. Each channel counts down from a programmed period at a rate set by two stages. The first is an 8-bit prescaler, and each prescaler serves two channels. The second is a per-channel power-of-two divider. The output is high while the live count is at or below a compare value. A polarity bit flips the waveform, and a mode bit picks between a free-running waveform and a single period that stops by itself.

Whenever a channel's count passes through zero it sets a sticky status flag. Each flag can be routed to one shared interrupt line. Software clears a flag by writing a one to it. New period and compare values are picked up at the next reload, so a waveform never changes in the middle of a period. Software can read the live count and the compare value currently in use.

Top module: `qpwm_timer`

## Requirements
- R1: After reset every register reads 0, every pwm_o bit is low and irq_o is low.
- R2: Register layout. 0x00 is the prescaler word: bits [7:0] serve channels 0 and 1, bits [15:8] serve channels 2 and 3, and bits [31:16] read 0. 0x04 holds a 3-bit divider code for channel c at bit 4c, and all other bits read 0. 0x08 holds a 4-bit control nibble at bit offsets 0, 8, 12 and 16 for channels 0 to 3; in each nibble bit 0 enables, bit 2 inverts and bit 3 selects free-running mode (set) or single period (clear). 0x3C holds the interrupt enables (bit c). 0x40 holds the status flags (bit c). Channel c has its period at 0x0C+12c, its compare value at 0x10+12c, its live count at 0x14+12c and its active compare at 0x44+4c.
- R3: A channel's count steps once every (P+1)·D clock cycles. P is the prescaler field of its pair. D is 2, 4, 8, 16 or 1 for divider codes 0, 1, 2, 3 and 4, and codes 5 to 7 also give 1. A free-running channel repeats every (P+1)·D·(N+1) cycles, where N is its period value.
- R4: With compare value M less than N, the output is high for (P+1)·D·(M+1) cycles of each period, in one contiguous run.
- R5: With N non-zero and M ≥ N, an enabled, non-inverted channel's output stays high.
- R6: With N = 0 an enabled, non-inverted channel's output stays low.
- R7: Setting the invert bit complements the output of an enabled channel: the high time becomes (P+1)·D·(N−M), and a saturated channel stays low.
- R8: In single-period mode the channel counts from N down to 0 once and then halts. Its count reads 0 and its non-inverted output stays low until it is disabled and enabled again.
- R9: A channel's status flag sets when its count steps from 0. Writing 1 to the flag clears it, and writing 0 leaves it set. irq_o is the OR of the flags whose enable bits are set.
- R10: Period and compare writes to a running channel take effect at its next reload. The live-count register returns the changing count, which never exceeds the period in use.
- R11: Channels 0 and 1 take their prescale from bits [7:0] alone, and channels 2 and 3 from bits [15:8] alone.
- R12: A channel whose enable bit is clear drives its output low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W (8) | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pwm_o | output | 4 | One waveform per channel |
| irq_o | output | 1 | Masked OR of the status flags |

## Verification
The hardest case to reach from the ports is a period change that lands while a channel is mid-cycle. The bench must show that the period in progress completes with the old length and that only the next one uses the new value. To do this, the stimulus writes a new period into a running channel and discards the one measurement that straddles the write. It then times the next full rising-edge-to-rising-edge interval. Constrained random cases vary the channel, the prescaler, all eight divider codes, the period, the compare value and the polarity. Directed cases cover saturation, a zero period, the single-period halt with its interrupt, and the pairing of the prescalers.

// File: rtl/qpwm_pkg.sv
package qpwm_pkg;

    localparam int NCH   = 4;
    localparam int SEL_W = 3;
    localparam int CTL_W = 4;
    localparam int DIV_W = 4;

    // control nibble bit positions
    localparam int CTL_EN  = 0;
    localparam int CTL_INV = 2;
    localparam int CTL_TGL = 3;

    // shared register offsets
    localparam int A_PRE = 'h00;
    localparam int A_SEL = 'h04;
    localparam int A_CTL = 'h08;
    localparam int A_IEN = 'h3C;
    localparam int A_STS = 'h40;

    function automatic int per_off(input int c);
        return 'h0C + 12 * c;
    endfunction

    function automatic int cmp_off(input int c);
        return 'h10 + 12 * c;
    endfunction

    function automatic int cnt_off(input int c);
        return 'h14 + 12 * c;
    endfunction

    function automatic int act_off(input int c);
        return 'h44 + 4 * c;
    endfunction

    // control nibble lsb: 0, 8, 12, 16
    function automatic int ctl_lsb(input int c);
        return (c == 0) ? 0 : 4 + 4 * c;
    endfunction

    // divider code -> terminal count (divide factor minus one)
    function automatic logic [DIV_W-1:0] div_last(input logic [SEL_W-1:0] code);
        logic [DIV_W-1:0] r;
        case (code)
            3'd0:    r = 4'd1;
            3'd1:    r = 4'd3;
            3'd2:    r = 4'd7;
            3'd3:    r = 4'd15;
            default: r = 4'd0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/qpwm_prescaler.sv
module qpwm_prescaler #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic [PRE_W-1:0] limit,
    output logic             tick
);

    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d  = s_q;
        tick = active && (s_q.cnt >= limit);
        if (!active || tick) begin
            s_d.cnt = '0;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/qpwm_channel.sv
module qpwm_channel
    import qpwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             toggle,
    input  logic             inv,
    input  logic [SEL_W-1:0] sel,
    input  logic [CNT_W-1:0] per_in,
    input  logic [CNT_W-1:0] cmp_in,
    input  logic             pre_tick,
    output logic             pwm,
    output logic             zero_evt,
    output logic             run,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] per_act,
    output logic [CNT_W-1:0] cmp_act
);

    typedef struct packed {
        logic             en_prev;
        logic             run;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] per;
        logic [CNT_W-1:0] cmp;
        logic [DIV_W-1:0] div;
    } st_t;

    st_t s_d, s_q;

    logic [DIV_W-1:0] last;
    logic             start;
    logic             step;
    logic             raw;

    always_comb begin
        s_d       = s_q;
        last      = div_last(sel);
        start     = en && !s_q.en_prev;
        step      = s_q.run && pre_tick && (s_q.div >= last);
        s_d.en_prev = en;

        if (s_q.run && pre_tick) begin
            s_d.div = step ? '0 : s_q.div + 1'b1;
        end

        if (!en) begin
            s_d.run = 1'b0;
        end else if (start) begin
            s_d.run = 1'b1;
            s_d.cnt = per_in;
            s_d.per = per_in;
            s_d.cmp = cmp_in;
            s_d.div = '0;
        end else if (step) begin
            if (s_q.cnt == '0) begin
                if (toggle) begin
                    s_d.cnt = per_in;
                    s_d.per = per_in;
                    s_d.cmp = cmp_in;
                end else begin
                    s_d.run = 1'b0;
                end
            end else begin
                s_d.cnt = s_q.cnt - 1'b1;
            end
        end

        zero_evt = en && !start && step && (s_q.cnt == '0);
        raw      = s_q.run && (s_q.per != '0) && (s_q.cnt <= s_q.cmp);
        pwm      = en && (raw ^ inv);
        run      = s_q.run;
        cnt      = s_q.cnt;
        per_act  = s_q.per;
        cmp_act  = s_q.cmp;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/qpwm_timer.sv
module qpwm_timer
    import qpwm_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 16,
    parameter int PRE_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [NCH-1:0]    pwm_o,
    output logic              irq_o
);

    localparam int NPAIR = NCH / 2;

    typedef struct packed {
        logic [NPAIR-1:0][PRE_W-1:0] pre;
        logic [NCH-1:0][SEL_W-1:0]   sel;
        logic [NCH-1:0][CTL_W-1:0]   ctl;
        logic [NCH-1:0][CNT_W-1:0]   per;
        logic [NCH-1:0][CNT_W-1:0]   cmp;
        logic [NCH-1:0]              ien;
        logic [NCH-1:0]              sts;
    } regs_t;

    regs_t r_d, r_q;

    logic [NPAIR-1:0]            pre_tick;
    logic [NCH-1:0]              ch_en, ch_inv, ch_tgl, ch_run, ch_zero;
    logic [NCH-1:0][CNT_W-1:0]   ch_cnt, ch_per, ch_cmp;
    logic [NCH-1:0]              sts_clr;

    for (genvar c = 0; c < NCH; c++) begin : g_ctl
        assign ch_en[c]  = r_q.ctl[c][CTL_EN];
        assign ch_inv[c] = r_q.ctl[c][CTL_INV];
        assign ch_tgl[c] = r_q.ctl[c][CTL_TGL];
    end

    for (genvar p = 0; p < NPAIR; p++) begin : g_pre
        qpwm_prescaler #(.PRE_W(PRE_W)) u_pre (
            .clk    (clk),
            .rst_n  (rst_n),
            .active (ch_en[2*p] | ch_en[2*p+1]),
            .limit  (r_q.pre[p]),
            .tick   (pre_tick[p])
        );
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        qpwm_channel #(.CNT_W(CNT_W)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (ch_en[c]),
            .toggle   (ch_tgl[c]),
            .inv      (ch_inv[c]),
            .sel      (r_q.sel[c]),
            .per_in   (r_q.per[c]),
            .cmp_in   (r_q.cmp[c]),
            .pre_tick (pre_tick[c/2]),
            .pwm      (pwm_o[c]),
            .zero_evt (ch_zero[c]),
            .run      (ch_run[c]),
            .cnt      (ch_cnt[c]),
            .per_act  (ch_per[c]),
            .cmp_act  (ch_cmp[c])
        );
    end

    // next-state of the register file
    always_comb begin
        r_d     = r_q;
        sts_clr = '0;
        if (bus_we) begin
            if (bus_addr == ADDR_W'(A_PRE)) r_d.pre = bus_wdata[NPAIR*PRE_W-1:0];
            if (bus_addr == ADDR_W'(A_IEN)) r_d.ien = bus_wdata[NCH-1:0];
            if (bus_addr == ADDR_W'(A_STS)) sts_clr = bus_wdata[NCH-1:0];
            for (int c = 0; c < NCH; c++) begin
                if (bus_addr == ADDR_W'(A_SEL)) r_d.sel[c] = bus_wdata[4*c +: SEL_W];
                if (bus_addr == ADDR_W'(A_CTL)) r_d.ctl[c] = bus_wdata[ctl_lsb(c) +: CTL_W];
                if (bus_addr == ADDR_W'(per_off(c))) r_d.per[c] = bus_wdata[CNT_W-1:0];
                if (bus_addr == ADDR_W'(cmp_off(c))) r_d.cmp[c] = bus_wdata[CNT_W-1:0];
            end
        end
        r_d.sts = (r_q.sts & ~sts_clr) | ch_zero;
    end

    // read decode
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(A_PRE)) bus_rdata = 32'(r_q.pre);
        if (bus_addr == ADDR_W'(A_IEN)) bus_rdata = 32'(r_q.ien);
        if (bus_addr == ADDR_W'(A_STS)) bus_rdata = 32'(r_q.sts);
        for (int c = 0; c < NCH; c++) begin
            if (bus_addr == ADDR_W'(A_SEL)) bus_rdata[4*c +: SEL_W] = r_q.sel[c];
            if (bus_addr == ADDR_W'(A_CTL)) bus_rdata[ctl_lsb(c) +: CTL_W] = r_q.ctl[c];
            if (bus_addr == ADDR_W'(per_off(c))) bus_rdata = 32'(r_q.per[c]);
            if (bus_addr == ADDR_W'(cmp_off(c))) bus_rdata = 32'(r_q.cmp[c]);
            if (bus_addr == ADDR_W'(cnt_off(c))) bus_rdata = 32'(ch_cnt[c]);
            if (bus_addr == ADDR_W'(act_off(c))) bus_rdata = 32'(ch_cmp[c]);
        end
    end

    assign irq_o = |(r_q.sts & r_q.ien);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

endmodule

// File: rtl/qpwm_timer_chk.sv
module qpwm_timer_chk #(
    parameter int NCH   = 4,
    parameter int CNT_W = 16
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [NCH-1:0]            pwm_o,
    input logic [NCH-1:0]            en,
    input logic [NCH-1:0]            inv,
    input logic [NCH-1:0]            tgl,
    input logic [NCH-1:0]            run,
    input logic [NCH-1:0]            zero_evt,
    input logic [NCH-1:0]            sts,
    input logic [NCH-1:0][CNT_W-1:0] cnt,
    input logic [NCH-1:0][CNT_W-1:0] per_act,
    input logic [NCH-1:0][CNT_W-1:0] cmp_act
);

    for (genvar c = 0; c < NCH; c++) begin : g_a
        AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
            !en[c] |-> !pwm_o[c]); // R12
        AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
            run[c] |-> (cnt[c] <= per_act[c])); // R10
        AST_ONESHOT_HALT: assert property (@(posedge clk) disable iff (!rst_n)
            (zero_evt[c] && !tgl[c] && en[c]) |=> !run[c]); // R8
        AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
            zero_evt[c] |=> sts[c]); // R9
        AST_FULL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
            (run[c] && en[c] && !inv[c] && per_act[c] != '0 && cmp_act[c] >= per_act[c])
            |-> pwm_o[c]); // R5
        AST_PERIOD0_LOW: assert property (@(posedge clk) disable iff (!rst_n)
            (run[c] && !inv[c] && per_act[c] == '0) |-> !pwm_o[c]); // R6
    end

endmodule

bind qpwm_timer qpwm_timer_chk #(.NCH(qpwm_pkg::NCH), .CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwm_o    (pwm_o),
    .en       (ch_en),
    .inv      (ch_inv),
    .tgl      (ch_tgl),
    .run      (ch_run),
    .zero_evt (ch_zero),
    .sts      (r_q.sts),
    .cnt      (ch_cnt),
    .per_act  (ch_per),
    .cmp_act  (ch_cmp)
);

// File: tb/qpwm_timer_test.sv
`timescale 1ns/1ps
module qpwm_timer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  pwm_o;
    logic        irq_o;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    qpwm_timer uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_o(pwm_o), .irq_o(irq_o)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = 8'(a); bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = 8'(a);
        #1 d = bus_rdata;
    endtask

    function automatic int divf(input int code);
        case (code)
            0: return 2;
            1: return 4;
            2: return 8;
            3: return 16;
            default: return 1;
        endcase
    endfunction

    function automatic int ctl_sh(input int c);
        return (c == 0) ? 0 : 4 + 4 * c;
    endfunction

    // time one full period from a rising edge to the next
    task automatic measure(input int c, output int per, output int hi);
        int guard = 0;
        logic prev;
        per = 0; hi = 0;
        while (pwm_o[c] !== 1'b0 && guard < 20000) begin @(negedge clk); guard++; end
        while (pwm_o[c] !== 1'b1 && guard < 20000) begin @(negedge clk); guard++; end
        forever begin
            if (pwm_o[c]) hi++;
            per++;
            prev = pwm_o[c];
            @(negedge clk);
            guard++;
            if ((!prev && pwm_o[c]) || guard >= 20000) break;
        end
        if (guard >= 20000) begin per = -1; hi = -1; end
    endtask

    task automatic count_high(input int c, input int n, output int hi);
        hi = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_o[c]) hi++;
        end
    endtask

    // program and start one free-running channel, all others off
    task automatic setup(input int c, input int pre, input int code, input int n,
                         input int m, input bit inv);
        wr('h08, 0);
        wr('h00, 32'(pre | (pre << 8)));
        wr('h04, 32'(code << (4 * c)));
        wr('h0C + 12 * c, 32'(n));
        wr('h10 + 12 * c, 32'(m));
        wr('h08, 32'((9 | (int'(inv) << 2)) << ctl_sh(c)));
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, v2;
        int per, hi, bad;
        void'($urandom(32'd2024));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        bad = 0;
        for (int a = 0; a <= 'h50; a += 4) begin
            rd(a, v);
            if (v != 0) bad++;
        end
        check(bad == 0, "R1 registers zero", bad, 0);
        check(pwm_o == 0 && irq_o == 0, "R1 outputs idle", {pwm_o, irq_o}, 0);

        // R2: field layout and masking
        wr('h04, 32'hFFFF_FFFF); rd('h04, v);
        check(v == 32'h0000_7777, "R2 divider fields", v, 32'h7777);
        wr('h00, 32'hFFFF_FFFF); rd('h00, v);
        check(v == 32'h0000_FFFF, "R2 prescaler word", v, 32'hFFFF);
        wr('h08, 32'hFFFF_FFFF); rd('h08, v);
        check(v == 32'h000F_FF0F, "R2 control nibbles", v, 32'h000FFF0F);
        wr('h08, 0);
        wr('h34, 32'h0001_2345); rd('h34, v);
        check(v == 32'h2345, "R2 compare reg ch3", v, 32'h2345);
        wr('h40, 32'hF);

        // R3 R4 R7: random free-running cases
        for (int k = 0; k < 16; k++) begin
            int c, pre, code, n, m, tk, ep, eh;
            bit inv;
            c = int'($urandom % 4); pre = int'($urandom % 4); code = int'($urandom % 8);
            n = 1 + int'($urandom % 15); m = int'($urandom % n); inv = 1'($urandom % 2);
            setup(c, pre, code, n, m, inv);
            measure(c, per, hi);
            measure(c, per, hi);
            tk = (pre + 1) * divf(code);
            ep = tk * (n + 1);
            eh = inv ? tk * (n - m) : tk * (m + 1);
            check(per == ep, "R3 period", per, ep);
            check(hi == eh, inv ? "R7 inverted high time" : "R4 high time", hi, eh);
        end

        // R5: saturation, compare equal and above period
        setup(3, 0, 1, 5, 5, 0);
        repeat (10) @(negedge clk);
        count_high(3, 100, hi);
        check(hi == 100, "R5 compare equals period", hi, 100);
        setup(3, 1, 0, 5, 9, 0);
        repeat (10) @(negedge clk);
        count_high(3, 100, hi);
        check(hi == 100, "R5 compare above period", hi, 100);
        // R7: inverted saturation stays low
        setup(3, 0, 4, 5, 9, 1);
        repeat (10) @(negedge clk);
        count_high(3, 100, hi);
        check(hi == 0, "R7 inverted saturation", hi, 0);

        // R6: zero period
        setup(1, 0, 4, 0, 5, 0);
        count_high(1, 100, hi);
        check(hi == 0, "R6 zero period low", hi, 0);

        // R12: disabled channel low
        wr('h0C, 7); wr('h10, 20);
        wr('h08, 32'h0000_0008);
        count_high(0, 60, hi);
        check(hi == 0, "R12 disabled low", hi, 0);

        // R11: pairing of prescalers
        wr('h08, 0);
        wr('h00, 32'h0000_0300);
        wr('h04, 32'h0000_0040);
        wr('h18, 4); wr('h1C, 1);
        wr('h08, 32'h0000_0900);
        measure(1, per, hi); measure(1, per, hi);
        check(per == 5, "R11 ch1 ignores high byte", per, 5);
        wr('h08, 0);
        wr('h00, 32'h0000_0002);
        wr('h04, 32'h0000_0000);
        wr('h08, 32'h0000_0900);
        measure(1, per, hi); measure(1, per, hi);
        check(per == 30 && hi == 12, "R11 ch1 uses low byte", per, 30);

        // R10: period change at reload, live count
        setup(0, 0, 4, 9, 4, 0);
        measure(0, per, hi);
        check(per == 10, "R10 initial period", per, 10);
        wr('h0C, 19);
        measure(0, per, hi);
        measure(0, per, hi);
        check(per == 20 && hi == 5, "R10 new period after reload", per, 20);
        rd('h14, v);
        repeat (2) @(negedge clk);
        rd('h14, v2);
        check(v <= 19 && v2 <= 19 && v != v2, "R10 live count", v2, v);
        rd('h44, v);
        check(v == 4, "R10 active compare", v, 4);

        // R8 R9: single period with interrupt
        wr('h08, 0);
        wr('h40, 32'hF);
        wr('h00, 0);
        wr('h04, 32'h0000_0400);
        wr('h24, 3); wr('h28, 1);
        wr('h3C, 32'h4);
        wr('h08, 32'h0000_1000);
        count_high(2, 60, hi);
        check(hi == 2, "R8 single period high time", hi, 2);
        check(pwm_o[2] == 0, "R8 halted low", pwm_o[2], 0);
        rd('h2C, v);
        check(v == 0, "R8 count reads zero", v, 0);
        check(irq_o == 1, "R9 irq raised", irq_o, 1);
        rd('h40, v);
        check(v == 4, "R9 status flag", v, 4);
        wr('h40, 0);
        @(negedge clk);
        check(irq_o == 1, "R9 write zero keeps flag", irq_o, 1);
        wr('h3C, 0);
        @(negedge clk);
        check(irq_o == 0, "R9 masked", irq_o, 0);
        wr('h3C, 32'h4);
        wr('h40, 32'h4);
        @(negedge clk);
        rd('h40, v);
        check(irq_o == 0 && v == 0, "R9 write one clears", v, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule